// File: doc/BRIEF.md
# Programmable PWM Channel

A single pulse-width modulation channel with a 16-bit counter that advances only on cycles where an external prescaler strobe is high. Software sets the output period and the high time, both counted in prescaled ticks, through a small register bus with single-cycle writes and combinational reads. The output is high at the start of each period and drops once the counter reaches the programmed high time. A period value of zero selects the longest period, 65536 ticks. At that period the output always spends the final tick low.

Period and high-time values written while the channel runs are held in staging registers. They move into the working copies only at the counter wrap, so a new setting never cuts a period short or adds a stray edge. Each wrap sets a sticky completion flag, which software clears by writing a one to it. When its enable bit is set, the flag drives the interrupt request.

Top module: `pwm_chan`

## Requirements
- R1: After reset every readable register returns zero, `pwm_out` is low and `irq` is low.
- R2: The counter advances by one only on clock edges where the enable bit (control bit 0) is set and `tick_en` is high. While the enable bit is clear, the counter is held at 0 and `pwm_out` is low.
- R3: With an active period value P, the counter counts 0, 1, ..., P-1 and then returns to 0. P = 0 means 65536 ticks.
- R4: While enabled, `pwm_out` is high exactly when the counter is below the active high-time value. A high time of 0 gives a constant low output.
- R5: A high time at or above the period gives a constant high output. The exception is a period of 65536 ticks: a high time of 0xFFFF is then low for the counter value 0xFFFF.
- R6: The counter keeps counting at 0% and at 100% duty.
- R7: Period and high-time writes made while enabled take effect only at the next wrap. While disabled, the working copies follow the written values.
- R8: The completion flag (control bit 15) sets on every wrap. Writing 1 to bit 15 clears it and writing 0 leaves it unchanged. A wrap in the same cycle as a clearing write leaves it set.
- R9: `irq` is high exactly when the completion flag is set and the interrupt enable bit (control bit 1) is set.
- R10: The register map is as follows. Address 0 is control. Address 1 is period. Address 2 is high time. Address 3 is the counter, which is read-only. Addresses 4 to 7 read zero and ignore writes. The unused control bits read zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_en | input | 1 | Prescaled tick strobe; the counter advances on cycles where it is high |
| bus_we | input | 1 | Register write strobe |
| bus_addr | input | ADDR_W (3) | Register address |
| bus_wdata | input | DATA_W (16) | Write data |
| bus_rdata | output | DATA_W (16) | Read data for `bus_addr`, combinational |
| pwm_out | output | 1 | Modulated output |
| irq | output | 1 | Interrupt request |

## Verification
The output is compared every cycle against a tick-level model under four kinds of stimulus:
- A short period with a mid-range high time and a strobe on every cycle separates correct wrap placement from off-by-one errors in the period or the compare.
- A sparse strobe shows that counting follows the strobe and not the clock.
- Zero and oversized high times show that the counter keeps running at both saturated duties.
- A full run at the 65536-tick period with a 0xFFFF high time shows that the final tick stays low.

Writes made in the middle of a period, and a clearing write placed on the wrap cycle, show whether staging and flag priority follow the wrap.

// File: rtl/pwm_pkg.sv
package pwm_pkg;
   localparam int REG_CTRL   = 0;
   localparam int REG_PERIOD = 1;
   localparam int REG_WIDTH  = 2;
   localparam int REG_COUNT  = 3;

   localparam int CTRL_EN_BIT = 0;
   localparam int CTRL_IE_BIT = 1;
endpackage

// File: rtl/pwm_regfile.sv
module pwm_regfile
   import pwm_pkg::*;
#(
   parameter int CNT_W  = 16,
   parameter int DATA_W = 16,
   parameter int ADDR_W = 3
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              we,
   input  logic [ADDR_W-1:0] addr,
   input  logic [DATA_W-1:0] wdata,
   input  logic              wrap,
   input  logic [CNT_W-1:0]  cnt,
   output logic              en_q,
   output logic              ie_q,
   output logic              flag_q,
   output logic [CNT_W-1:0]  per_q,
   output logic [CNT_W-1:0]  wid_q,
   output logic [DATA_W-1:0] rdata
);
   localparam int FLAG_BIT = DATA_W - 1;
   localparam int PAD      = DATA_W - CNT_W;

   logic [DATA_W-1:0] cnt_ext, per_ext, wid_ext, ctrl_word;
   logic sel_ctrl, sel_per, sel_wid, sel_cnt;

   assign sel_ctrl = (addr == ADDR_W'(REG_CTRL));
   assign sel_per  = (addr == ADDR_W'(REG_PERIOD));
   assign sel_wid  = (addr == ADDR_W'(REG_WIDTH));
   assign sel_cnt  = (addr == ADDR_W'(REG_COUNT));

   generate
      if (PAD > 0) begin : g_pad
         assign cnt_ext = {{PAD{1'b0}}, cnt};
         assign per_ext = {{PAD{1'b0}}, per_q};
         assign wid_ext = {{PAD{1'b0}}, wid_q};
      end else begin : g_nopad
         assign cnt_ext = cnt;
         assign per_ext = per_q;
         assign wid_ext = wid_q;
      end
   endgenerate

   always_comb begin
      ctrl_word = '0;
      ctrl_word[CTRL_EN_BIT] = en_q;
      ctrl_word[CTRL_IE_BIT] = ie_q;
      ctrl_word[FLAG_BIT]    = flag_q;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         en_q   <= 1'b0;
         ie_q   <= 1'b0;
         flag_q <= 1'b0;
         per_q  <= '0;
         wid_q  <= '0;
      end else begin
         if (we && sel_ctrl) begin
            en_q <= wdata[CTRL_EN_BIT];
            ie_q <= wdata[CTRL_IE_BIT];
         end
         if (we && sel_per) per_q <= wdata[CNT_W-1:0];
         if (we && sel_wid) wid_q <= wdata[CNT_W-1:0];
         if (wrap)
            flag_q <= 1'b1;
         else if (we && sel_ctrl && wdata[FLAG_BIT])
            flag_q <= 1'b0;
      end
   end

   always_comb begin
      if (sel_ctrl)     rdata = ctrl_word;
      else if (sel_per) rdata = per_ext;
      else if (sel_wid) rdata = wid_ext;
      else if (sel_cnt) rdata = cnt_ext;
      else              rdata = '0;
   end
endmodule

// File: rtl/pwm_counter.sv
module pwm_counter #(
   parameter int CNT_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             en,
   input  logic             tick,
   input  logic [CNT_W-1:0] per_stage,
   input  logic [CNT_W-1:0] wid_stage,
   output logic [CNT_W-1:0] cnt_q,
   output logic [CNT_W-1:0] last_act,
   output logic [CNT_W-1:0] wid_act,
   output logic             wrap
);
   logic [CNT_W-1:0] last_stage;

   // A period value of zero wraps to all ones, giving 2**CNT_W ticks.
   assign last_stage = per_stage - 1'b1;
   assign wrap       = en && tick && (cnt_q == last_act);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cnt_q    <= '0;
         last_act <= '1;
         wid_act  <= '0;
      end else if (!en) begin
         cnt_q    <= '0;
         last_act <= last_stage;
         wid_act  <= wid_stage;
      end else if (tick) begin
         if (wrap) begin
            cnt_q    <= '0;
            last_act <= last_stage;
            wid_act  <= wid_stage;
         end else begin
            cnt_q <= cnt_q + 1'b1;
         end
      end
   end
endmodule

// File: rtl/pwm_compare.sv
module pwm_compare #(
   parameter int CNT_W = 16
) (
   input  logic             en,
   input  logic [CNT_W-1:0] cnt,
   input  logic [CNT_W-1:0] wid_act,
   output logic             level
);
   assign level = en && (cnt < wid_act);
endmodule

// File: rtl/pwm_chan.sv
module pwm_chan #(
   parameter int CNT_W  = 16,
   parameter int DATA_W = 16,
   parameter int ADDR_W = 3
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              tick_en,
   input  logic              bus_we,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [DATA_W-1:0] bus_wdata,
   output logic [DATA_W-1:0] bus_rdata,
   output logic              pwm_out,
   output logic              irq
);
   generate
      if (CNT_W > DATA_W) begin : g_bad_width
         $error("pwm_chan: CNT_W must not exceed DATA_W");
      end
      if (DATA_W < 3) begin : g_bad_data
         $error("pwm_chan: DATA_W must be at least 3");
      end
      if (ADDR_W < 2) begin : g_bad_addr
         $error("pwm_chan: ADDR_W must be at least 2");
      end
   endgenerate

   logic             en_q, ie_q, flag_q, wrap;
   logic [CNT_W-1:0] per_q, wid_q, cnt_q, last_act, wid_act;

   pwm_regfile #(.CNT_W(CNT_W), .DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_regs (
      .clk(clk), .rst_n(rst_n), .we(bus_we), .addr(bus_addr), .wdata(bus_wdata),
      .wrap(wrap), .cnt(cnt_q), .en_q(en_q), .ie_q(ie_q), .flag_q(flag_q),
      .per_q(per_q), .wid_q(wid_q), .rdata(bus_rdata)
   );

   pwm_counter #(.CNT_W(CNT_W)) u_cnt (
      .clk(clk), .rst_n(rst_n), .en(en_q), .tick(tick_en),
      .per_stage(per_q), .wid_stage(wid_q), .cnt_q(cnt_q),
      .last_act(last_act), .wid_act(wid_act), .wrap(wrap)
   );

   pwm_compare #(.CNT_W(CNT_W)) u_cmp (
      .en(en_q), .cnt(cnt_q), .wid_act(wid_act), .level(pwm_out)
   );

   assign irq = flag_q && ie_q;
endmodule

// File: rtl/pwm_chan_chk.sv
module pwm_chan_chk #(
   parameter int CNT_W = 16
) (
   input logic             clk,
   input logic             rst_n,
   input logic             tick,
   input logic             en,
   input logic [CNT_W-1:0] cnt,
   input logic [CNT_W-1:0] last,
   input logic [CNT_W-1:0] wid,
   input logic             flag,
   input logic             ie,
   input logic             pwm_out,
   input logic             irq
);
   a_r2_hold_without_tick: assert property (@(posedge clk) disable iff (!rst_n)
      (en && !tick) |=> $stable(cnt));
   a_r2_idle_zero: assert property (@(posedge clk) disable iff (!rst_n)
      !en |=> (cnt == '0));
   a_r2_idle_low: assert property (@(posedge clk) disable iff (!rst_n)
      !en |-> !pwm_out);
   a_r3_in_range: assert property (@(posedge clk) disable iff (!rst_n)
      en |-> (cnt <= last));
   a_r3_wrap_zero: assert property (@(posedge clk) disable iff (!rst_n)
      (en && tick && cnt == last) |=> (cnt == '0));
   a_r4_zero_width: assert property (@(posedge clk) disable iff (!rst_n)
      (wid == '0) |-> !pwm_out);
   a_r8_flag_on_wrap: assert property (@(posedge clk) disable iff (!rst_n)
      (en && tick && cnt == last) |=> flag);
   a_r9_irq_needs_flag: assert property (@(posedge clk) disable iff (!rst_n)
      irq |-> (flag && ie));
endmodule

bind pwm_chan pwm_chan_chk #(.CNT_W(CNT_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .tick(tick_en), .en(en_q), .cnt(cnt_q),
   .last(last_act), .wid(wid_act), .flag(flag_q), .ie(ie_q),
   .pwm_out(pwm_out), .irq(irq)
);

// File: tb/tb_pwm_chan.sv
module tb_pwm_chan;
   localparam int CLK_PERIOD = 10;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        tick_en = 1'b0;
   logic        bus_we = 1'b0;
   logic [2:0]  bus_addr = '0;
   logic [15:0] bus_wdata = '0;
   logic [15:0] bus_rdata;
   logic        pwm_out, irq;

   int checks = 0;
   int errors = 0;

   // reference model state
   logic        m_en = 0, m_ie = 0, m_flag = 0;
   logic [15:0] m_cnt = 0, m_ps = 0, m_ws = 0, m_last = 16'hFFFF, m_wa = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   pwm_chan dut (
      .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .bus_we(bus_we),
      .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
      .pwm_out(pwm_out), .irq(irq)
   );

   function automatic logic [15:0] m_read(input logic [2:0] a);
      case (a)
         3'd0: m_read = {m_flag, 13'd0, m_ie, m_en};
         3'd1: m_read = m_ps;
         3'd2: m_read = m_ws;
         3'd3: m_read = m_cnt;
         default: m_read = 16'h0;
      endcase
   endfunction

   task automatic check(input string tag, input string what, input logic [15:0] act, input logic [15:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s %s: actual %h expected %h (t=%0t)", tag, what, act, exp, $time);
      end
   endtask

   // Runs one clock: drive at negedge, check, advance model at posedge.
   task automatic step(input bit t, input bit w, input logic [2:0] a, input logic [15:0] d, input string tag);
      logic wrap;
      tick_en = t; bus_we = w; bus_addr = a; bus_wdata = d;
      #1;
      check(tag, "pwm_out", {15'd0, pwm_out}, {15'd0, m_en && (m_cnt < m_wa)});
      check(tag, "irq", {15'd0, irq}, {15'd0, m_flag && m_ie});
      if (!w) check(tag, "rdata", bus_rdata, m_read(a));
      @(posedge clk);
      wrap = m_en && t && (m_cnt == m_last);
      if (!m_en) begin
         m_cnt = 0; m_wa = m_ws; m_last = m_ps - 16'd1;
      end else if (t) begin
         if (wrap) begin
            m_cnt = 0; m_wa = m_ws; m_last = m_ps - 16'd1;
         end else m_cnt = m_cnt + 16'd1;
      end
      if (wrap) m_flag = 1'b1;
      else if (w && a == 3'd0 && d[15]) m_flag = 1'b0;
      if (w) begin
         if (a == 3'd0) begin m_en = d[0]; m_ie = d[1]; end
         if (a == 3'd1) m_ps = d;
         if (a == 3'd2) m_ws = d;
      end
      @(negedge clk);
      tick_en = 0; bus_we = 0;
   endtask

   task automatic run(input int n, input int every, input string tag);
      for (int i = 0; i < n; i++) step((i % every) == 0, 1'b0, 3'd3, 16'h0, tag);
   endtask

   task automatic t_reset;
      for (int a = 0; a < 8; a++) step(1'b0, 1'b0, 3'(a), 16'h0, "R1");
   endtask

   task automatic t_map;
      for (int a = 3; a < 8; a++) step(1'b0, 1'b1, 3'(a), 16'hFFFF, "R10");
      for (int a = 0; a < 8; a++) step(1'b0, 1'b0, 3'(a), 16'h0, "R10");
      step(1'b0, 1'b1, 3'd0, 16'h7FFC, "R10");
      step(1'b0, 1'b0, 3'd0, 16'h0, "R10");
      step(1'b0, 1'b1, 3'd1, 16'h1234, "R10");
      step(1'b0, 1'b0, 3'd1, 16'h0, "R10");
   endtask

   task automatic t_basic;
      step(1'b0, 1'b1, 3'd1, 16'd5, "R3");
      step(1'b0, 1'b1, 3'd2, 16'd2, "R4");
      step(1'b0, 1'b1, 3'd0, 16'h0001, "R3");
      run(17, 1, "R3");
      run(8, 1, "R4");
   endtask

   task automatic t_shadow;
      run(2, 1, "R7");
      step(1'b1, 1'b1, 3'd2, 16'd4, "R7");
      step(1'b1, 1'b1, 3'd1, 16'd6, "R7");
      run(20, 1, "R7");
   endtask

   task automatic t_prescale;
      run(24, 3, "R2");
      step(1'b0, 1'b1, 3'd0, 16'h0000, "R2");
      run(10, 1, "R2");
   endtask

   task automatic t_duty;
      step(1'b0, 1'b1, 3'd1, 16'd5, "R6");
      step(1'b0, 1'b1, 3'd2, 16'd0, "R4");
      step(1'b0, 1'b1, 3'd0, 16'h0001, "R6");
      run(12, 1, "R6");
      step(1'b1, 1'b1, 3'd2, 16'd9, "R5");
      run(14, 1, "R5");
      run(6, 2, "R6");
   endtask

   task automatic t_flag;
      step(1'b0, 1'b1, 3'd0, 16'h8003, "R9");
      run(7, 1, "R9");
      step(1'b0, 1'b1, 3'd0, 16'h0003, "R8");
      step(1'b0, 1'b0, 3'd0, 16'h0, "R8");
      step(1'b0, 1'b1, 3'd0, 16'h8003, "R8");
      step(1'b0, 1'b0, 3'd0, 16'h0, "R8");
      while (m_cnt != m_last) step(1'b1, 1'b0, 3'd3, 16'h0, "R8");
      step(1'b1, 1'b1, 3'd0, 16'h8003, "R8");
      step(1'b0, 1'b0, 3'd0, 16'h0, "R8");
      step(1'b0, 1'b1, 3'd0, 16'h8001, "R9");
      step(1'b0, 1'b0, 3'd0, 16'h0, "R9");
   endtask

   task automatic t_long;
      step(1'b0, 1'b1, 3'd0, 16'h0000, "R5");
      step(1'b0, 1'b1, 3'd1, 16'h0000, "R3");
      step(1'b0, 1'b1, 3'd2, 16'hFFFF, "R5");
      step(1'b0, 1'b1, 3'd0, 16'h0001, "R5");
      run(65540, 1, "R5");
   endtask

   initial begin
      repeat (3) @(posedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_map();
      t_basic();
      t_shadow();
      t_prescale();
      t_duty();
      t_flag();
      t_long();
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      repeat (190000) @(posedge clk);
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule